// File: doc/BRIEF.md
# Branch Condition and Count Unit

This block decides whether a conditional branch is taken. It keeps two pieces of architectural state: a condition register made of eight 4-bit flag fields, and a 32-bit loop count register. A compare port writes the less-than, greater-than and equal flags of one chosen field from a signed or unsigned comparison of two operands. A record port writes field 0 from a signed test of a result against zero. A sticky overflow input supplies the fourth flag of each field written.

The branch port names one of the 32 condition bits, the truth value it must have, and whether the count register takes part. When it does, the count is decremented and the branch tests the new count for non-zero or zero, optionally together with the bit test. The decision comes back in the same cycle. Branch evaluation never writes a condition bit. Software loads and reads the count only through the move port, and a move wins over a decrement in the same cycle.

Top module: `branch_cond_unit`

## Requirements
- R1: After reset the condition register reads 0, the count reads 0 and no branch is reported taken.
- R2: A signed compare writes field cmp_field with LT, GT, EQ from the two's-complement order of cmp_a and cmp_b; field k sits at cr_out[31-4k -: 4] with LT in the highest bit, then GT, EQ, SO; other fields keep their value.
- R3: An unsigned compare (cmp_signed low) sets the same flags from the unsigned order of the operands.
- R4: The SO bit of every field written by a compare or record takes the value of so_in in that cycle.
- R5: A record write sets field 0 from a signed test of rec_value against zero; when a compare also targets field 0 in the same cycle, the compare wins.
- R6: Condition bit b (0 to 31) is cr_out[31-b]; with br_use_cond high the branch is taken only if that bit equals br_want.
- R7: A branch with br_use_ctr high decrements the count on the next edge and, with br_ctr_zero low, is taken only if the decremented count is non-zero.
- R8: With br_ctr_zero high the count test passes only when the decremented count is zero.
- R9: Count test and bit test may be combined; the branch is taken only when both pass, and the count is decremented whether or not it is taken.
- R10: The decrement wraps: a count of 0 becomes 0xFFFFFFFF and counts as non-zero.
- R11: A move into the count register in the same cycle as a decrement sets the count to the moved value.
- R12: A branch leaves every condition bit unchanged, and a branch without the count option leaves the count unchanged.
- R13: With br_valid low, br_taken is 0 and the count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Compare write strobe |
| cmp_signed | input | 1 | 1 = signed compare, 0 = unsigned |
| cmp_field | input | 3 | Field written by the compare |
| cmp_a | input | 32 | First compare operand |
| cmp_b | input | 32 | Second compare operand (register or immediate) |
| rec_valid | input | 1 | Record result to field 0 |
| rec_value | input | 32 | Result tested against zero |
| so_in | input | 1 | Sticky overflow copied to SO |
| br_valid | input | 1 | Branch evaluation strobe |
| br_bit | input | 5 | Condition bit tested |
| br_want | input | 1 | Required value of the tested bit |
| br_use_cond | input | 1 | Enable bit test |
| br_use_ctr | input | 1 | Enable decrement and count test |
| br_ctr_zero | input | 1 | 1 = take on zero count, 0 = on non-zero |
| ctr_wr | input | 1 | Move into count register |
| ctr_wdata | input | 32 | Value moved into the count |
| ctr_rdata | output | 32 | Current count |
| cr_out | output | 32 | Current condition register |
| br_taken | output | 1 | Branch decision |

## Verification
The bench aims at the operand pairs where signed and unsigned order disagree, which a design that ignored the signedness select would flag with the wrong one of LT and GT. It walks a loop count down to one, where a design testing the count before the decrement would take one branch too many, and then past zero, where a missing wrap would stall the count or report it as zero. It fires a move and a decrement together, which a wrong priority would turn into a count one below the moved value, and it collides a compare with a record on field 0. It also branches on bits at both ends of the register with both required values to expose a reversed bit numbering.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
   typedef struct packed {
      logic lt;
      logic gt;
      logic eq;
      logic so;
   } cr_field_t;

   localparam int FIELD_W = 4;
endpackage

// File: rtl/bcu_compare.sv
module bcu_compare
   import bcu_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter bit USE_SUBTRACT = 1'b1
) (
   input  logic              is_signed,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic              so_in,
   output cr_field_t         flags
);
   logic less;
   logic same;

   assign same = (opa == opb);

   generate
      if (USE_SUBTRACT) begin : g_sub
         logic [DATA_W+1:0] ea;
         logic [DATA_W+1:0] eb;
         logic [DATA_W+1:0] diff;
         always_comb begin
            ea   = {{2{is_signed & opa[DATA_W-1]}}, opa};
            eb   = {{2{is_signed & opb[DATA_W-1]}}, opb};
            diff = ea - eb;
            less = diff[DATA_W+1];
         end
      end else begin : g_op
         always_comb begin
            if (is_signed) less = ($signed(opa) < $signed(opb));
            else           less = (opa < opb);
         end
      end
   endgenerate

   always_comb begin
      flags.lt = less;
      flags.gt = ~less & ~same;
      flags.eq = same;
      flags.so = so_in;
   end
endmodule

// File: rtl/bcu_cr_file.sv
module bcu_cr_file
   import bcu_pkg::*;
#(
   parameter int NFIELD = 8,
   localparam int FSEL_W = $clog2(NFIELD),
   localparam int CR_W   = FIELD_W * NFIELD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp_we,
   input  logic [FSEL_W-1:0] cmp_sel,
   input  cr_field_t         cmp_flags,
   input  logic              rec_we,
   input  cr_field_t         rec_flags,
   output logic [CR_W-1:0]   cr_q
);
   generate
      for (genvar k = 0; k < NFIELD; k++) begin : g_field
         localparam int HI = CR_W - 1 - FIELD_W * k;
         cr_field_t cur;
         cr_field_t nxt;
         assign cur = cr_field_t'(cr_q[HI -: FIELD_W]);
         always_comb begin
            nxt = cur;
            if (cmp_we && (cmp_sel == FSEL_W'(k))) nxt = cmp_flags;
            else if (rec_we && (k == 0))          nxt = rec_flags;
         end
         always_ff @(posedge clk) begin
            if (!rst_n) cr_q[HI -: FIELD_W] <= '0;
            else        cr_q[HI -: FIELD_W] <= nxt;
         end
      end
   endgenerate
endmodule

// File: rtl/bcu_count.sv
module bcu_count #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mv_we,
   input  logic [DATA_W-1:0] mv_data,
   input  logic              dec,
   output logic [DATA_W-1:0] cnt_q,
   output logic [DATA_W-1:0] cnt_dec
);
   assign cnt_dec = cnt_q - DATA_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt_q <= '0;
      else if (mv_we) cnt_q <= mv_data;
      else if (dec)   cnt_q <= cnt_dec;
   end
endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit
   import bcu_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int NFIELD       = 8,
   parameter bit USE_SUBTRACT = 1'b1,
   localparam int CR_W   = FIELD_W * NFIELD,
   localparam int FSEL_W = $clog2(NFIELD),
   localparam int BSEL_W = $clog2(CR_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp_valid,
   input  logic              cmp_signed,
   input  logic [FSEL_W-1:0] cmp_field,
   input  logic [DATA_W-1:0] cmp_a,
   input  logic [DATA_W-1:0] cmp_b,
   input  logic              rec_valid,
   input  logic [DATA_W-1:0] rec_value,
   input  logic              so_in,
   input  logic              br_valid,
   input  logic [BSEL_W-1:0] br_bit,
   input  logic              br_want,
   input  logic              br_use_cond,
   input  logic              br_use_ctr,
   input  logic              br_ctr_zero,
   input  logic              ctr_wr,
   input  logic [DATA_W-1:0] ctr_wdata,
   output logic [DATA_W-1:0] ctr_rdata,
   output logic [CR_W-1:0]   cr_out,
   output logic              br_taken
);
   generate
      if (NFIELD < 2 || (1 << FSEL_W) != NFIELD) begin : g_bad_nfield
         $error("NFIELD must be a power of two of at least 2");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
   endgenerate

   cr_field_t cmp_flags;
   cr_field_t rec_flags;
   logic [DATA_W-1:0] cnt_dec;
   logic sel_bit, cond_ok, cnt_nz, cnt_ok;

   bcu_compare #(.DATA_W(DATA_W), .USE_SUBTRACT(USE_SUBTRACT)) u_cmp (
      .is_signed(cmp_signed), .opa(cmp_a), .opb(cmp_b),
      .so_in(so_in), .flags(cmp_flags)
   );

   bcu_compare #(.DATA_W(DATA_W), .USE_SUBTRACT(USE_SUBTRACT)) u_rec (
      .is_signed(1'b1), .opa(rec_value), .opb('0),
      .so_in(so_in), .flags(rec_flags)
   );

   bcu_cr_file #(.NFIELD(NFIELD)) u_cr (
      .clk(clk), .rst_n(rst_n),
      .cmp_we(cmp_valid), .cmp_sel(cmp_field), .cmp_flags(cmp_flags),
      .rec_we(rec_valid), .rec_flags(rec_flags),
      .cr_q(cr_out)
   );

   bcu_count #(.DATA_W(DATA_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .mv_we(ctr_wr), .mv_data(ctr_wdata),
      .dec(br_valid & br_use_ctr),
      .cnt_q(ctr_rdata), .cnt_dec(cnt_dec)
   );

   always_comb begin
      sel_bit  = cr_out[BSEL_W'(CR_W - 1) - br_bit];
      cond_ok  = ~br_use_cond | (sel_bit == br_want);
      cnt_nz   = |cnt_dec;
      cnt_ok   = ~br_use_ctr | (cnt_nz ^ br_ctr_zero);
      br_taken = br_valid & cond_ok & cnt_ok;
   end
endmodule

// File: rtl/bcu_checker.sv
module bcu_checker #(
   parameter int DATA_W = 32,
   parameter int NFIELD = 8,
   localparam int CR_W   = 4 * NFIELD,
   localparam int FSEL_W = $clog2(NFIELD)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmp_valid,
   input logic [FSEL_W-1:0] cmp_field,
   input logic              rec_valid,
   input logic              so_in,
   input logic              br_valid,
   input logic              br_use_ctr,
   input logic              ctr_wr,
   input logic [DATA_W-1:0] ctr_wdata,
   input logic [DATA_W-1:0] ctr_rdata,
   input logic [CR_W-1:0]   cr_out,
   input logic              br_taken
);
   function automatic logic so_of(input logic [CR_W-1:0] cr, input logic [FSEL_W-1:0] f);
      return cr[CR_W - 4 - 4 * int'(f)];
   endfunction

   a_r7_decrement: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && br_use_ctr && !ctr_wr) |=> ctr_rdata == $past(ctr_rdata) - DATA_W'(1));

   a_r10_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && br_use_ctr && !ctr_wr && ctr_rdata == '0) |=> (&ctr_rdata));

   a_r11_move_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ctr_wr |=> ctr_rdata == $past(ctr_wdata));

   a_r12_cr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmp_valid && !rec_valid) |=> $stable(cr_out));

   a_r13_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
      (!br_valid && !ctr_wr) |=> $stable(ctr_rdata));

   a_r13_idle_taken: assert property (@(posedge clk) disable iff (!rst_n)
      !br_valid |-> !br_taken);

   a_r4_so_copy: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_valid |=> so_of(cr_out, $past(cmp_field)) == $past(so_in));
endmodule

bind branch_cond_unit bcu_checker #(.DATA_W(DATA_W), .NFIELD(NFIELD)) u_bcu_chk (
   .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_field(cmp_field),
   .rec_valid(rec_valid), .so_in(so_in), .br_valid(br_valid),
   .br_use_ctr(br_use_ctr), .ctr_wr(ctr_wr), .ctr_wdata(ctr_wdata),
   .ctr_rdata(ctr_rdata), .cr_out(cr_out), .br_taken(br_taken)
);

// File: tb/tb_branch_cond_unit.sv
module tb_branch_cond_unit;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cmp_valid, cmp_signed, rec_valid, so_in;
   logic [2:0]  cmp_field;
   logic [31:0] cmp_a, cmp_b, rec_value, ctr_wdata;
   logic        br_valid, br_want, br_use_cond, br_use_ctr, br_ctr_zero, ctr_wr;
   logic [4:0]  br_bit;
   logic [31:0] ctr_rdata, cr_out;
   logic        br_taken;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   branch_cond_unit dut (
      .clk(clk), .rst_n(rst_n),
      .cmp_valid(cmp_valid), .cmp_signed(cmp_signed), .cmp_field(cmp_field),
      .cmp_a(cmp_a), .cmp_b(cmp_b), .rec_valid(rec_valid), .rec_value(rec_value),
      .so_in(so_in), .br_valid(br_valid), .br_bit(br_bit), .br_want(br_want),
      .br_use_cond(br_use_cond), .br_use_ctr(br_use_ctr), .br_ctr_zero(br_ctr_zero),
      .ctr_wr(ctr_wr), .ctr_wdata(ctr_wdata),
      .ctr_rdata(ctr_rdata), .cr_out(cr_out), .br_taken(br_taken)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      cmp_valid = 0; cmp_signed = 0; cmp_field = 0; cmp_a = 0; cmp_b = 0;
      rec_valid = 0; rec_value = 0; so_in = 0;
      br_valid = 0; br_bit = 0; br_want = 0; br_use_cond = 0;
      br_use_ctr = 0; br_ctr_zero = 0; ctr_wr = 0; ctr_wdata = 0;
   endtask

   // inputs already set away from the edge; commit one edge, then clear
   task automatic step();
      @(posedge clk); #1;
      idle();
      @(negedge clk);
   endtask

   task automatic do_cmp(input logic sgn, input logic [2:0] f,
                         input logic [31:0] a, input logic [31:0] b, input logic so);
      cmp_valid = 1; cmp_signed = sgn; cmp_field = f; cmp_a = a; cmp_b = b; so_in = so;
      step();
   endtask

   task automatic move(input logic [31:0] v);
      ctr_wr = 1; ctr_wdata = v;
      step();
   endtask

   // sets up a branch, checks the same-cycle decision, then commits it
   task automatic branch(input string req, input logic [4:0] b, input logic want,
                         input logic uc, input logic ut, input logic tz, input logic exp);
      br_valid = 1; br_bit = b; br_want = want; br_use_cond = uc;
      br_use_ctr = ut; br_ctr_zero = tz;
      #1 check(req, {31'd0, br_taken}, {31'd0, exp});
      step();
   endtask

   task automatic t_reset();
      check("R1 cr", cr_out, 32'h0);
      check("R1 ctr", ctr_rdata, 32'h0);
      check("R1 taken", {31'd0, br_taken}, 32'h0);
   endtask

   task automatic t_signed();
      do_cmp(1, 3'd2, 32'hFFFF_FFFB, 32'd3, 0);
      check("R2 signed lt field2", cr_out, 32'h0080_0000);
      do_cmp(1, 3'd7, 32'd7, 32'd7, 0);
      check("R2 eq field7", cr_out, 32'h0080_0002);
   endtask

   task automatic t_unsigned();
      do_cmp(0, 3'd1, 32'hFFFF_FFFB, 32'd3, 1);
      check("R3 unsigned gt field1", cr_out, 32'h0580_0002);
      check("R4 so bit field1", {31'd0, cr_out[24]}, 32'd1);
   endtask

   task automatic t_record();
      rec_valid = 1; rec_value = 32'h8000_0000; so_in = 0;
      step();
      check("R5 record negative", cr_out, 32'h8580_0002);
      cmp_valid = 1; cmp_signed = 0; cmp_field = 0; cmp_a = 3; cmp_b = 1;
      rec_valid = 1; rec_value = 0;
      step();
      check("R5 compare wins field0", cr_out, 32'h4580_0002);
   endtask

   task automatic t_cond();
      branch("R6 bit1 want1", 5'd1, 1, 1, 0, 0, 1);
      branch("R6 bit1 want0", 5'd1, 0, 1, 0, 0, 0);
      branch("R6 bit30 want1", 5'd30, 1, 1, 0, 0, 1);
      branch("R6 bit31 want0", 5'd31, 0, 1, 0, 0, 1);
      branch("R6 bit0 want1", 5'd0, 1, 1, 0, 0, 0);
      check("R12 cr unchanged", cr_out, 32'h4580_0002);
      check("R12 ctr unchanged", ctr_rdata, 32'h0);
   endtask

   task automatic t_ctr();
      move(32'd3);
      check("R11 move", ctr_rdata, 32'd3);
      branch("R7 dec 3", 5'd0, 0, 0, 1, 0, 1);
      check("R7 ctr 2", ctr_rdata, 32'd2);
      branch("R7 dec 2", 5'd0, 0, 0, 1, 0, 1);
      branch("R7 dec 1 falls", 5'd0, 0, 0, 1, 0, 0);
      check("R7 ctr 0", ctr_rdata, 32'd0);
      branch("R10 wrap taken", 5'd0, 0, 0, 1, 0, 1);
      check("R10 wrap value", ctr_rdata, 32'hFFFF_FFFF);
   endtask

   task automatic t_zero();
      move(32'd1);
      branch("R8 zero taken", 5'd0, 0, 0, 1, 1, 1);
      check("R8 ctr 0", ctr_rdata, 32'd0);
      move(32'd5);
      branch("R8 zero not taken", 5'd0, 0, 0, 1, 1, 0);
      check("R8 ctr 4", ctr_rdata, 32'd4);
   endtask

   task automatic t_fused();
      branch("R9 both pass", 5'd1, 1, 1, 1, 0, 1);
      check("R9 ctr 3", ctr_rdata, 32'd3);
      branch("R9 bit fails", 5'd1, 0, 1, 1, 0, 0);
      check("R9 ctr 2 still dec", ctr_rdata, 32'd2);
      check("R12 cr after fused", cr_out, 32'h4580_0002);
   endtask

   task automatic t_prio();
      ctr_wr = 1; ctr_wdata = 32'h100;
      br_valid = 1; br_use_ctr = 1;
      step();
      check("R11 move beats dec", ctr_rdata, 32'h100);
   endtask

   task automatic t_idle();
      br_valid = 0; br_use_ctr = 1; br_use_cond = 1; br_bit = 5'd1; br_want = 1;
      #1 check("R13 taken low", {31'd0, br_taken}, 32'h0);
      step();
      check("R13 ctr held", ctr_rdata, 32'h100);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      idle();
      rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_signed();
      t_unsigned();
      t_record();
      t_cond();
      t_ctr();
      t_zero();
      t_fused();
      t_prio();
      t_idle();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule